// File: doc/BRIEF.md
# Accumulator Machine Control Unit

This block sequences an 8-bit single-accumulator processor. It holds the accumulator, a memory pointer, the program counter, the instruction register and a two-flag condition register. Each instruction is fetched from an external byte-wide memory, decoded and then executed over a few more memory cycles. Operand bytes can carry a constant, the address of a byte, or the address of a byte that itself holds an address. Direct and indirect operands are resolved through the memory pointer, which costs one or two extra bus cycles.

The memory interface is asynchronous-read. The block presents an address and samples the shared data bus in the same cycle. It drives the bus only during the single cycle in which it raises write-enable for a store. A freeze input stops the machine at an instruction boundary, so an outside agent can inspect or hold the system. Releasing the input lets execution carry on without any loss.

Top module: `acc_cpu_core`

## Requirements
- R1: While reset is held, and at the first fetch after it, all internal registers are zero, the address output is 0x00 and write-enable is low. Execution starts by fetching address 0x00.
- R2: Opcode 0x00 (no operation) occupies one byte. Every opcode from 0x25 to 0xFF is also executed as a one-byte no-operation and does not consume the following byte. All other opcodes take an operand byte.
- R3: Opcode 0x01 loads the operand constant into the accumulator and 0x02 loads the byte at the operand address. Opcode 0x03 stores the accumulator at the operand address and 0x04 stores it at the address held in the byte at the operand address.
- R4: Opcodes 0x05 to 0x1A form constant/direct pairs, with the constant form on the odd code, for the operations in this order: add, subtract (A minus operand), and, or, xor, logical left shift, logical right shift, arithmetic left shift, arithmetic right shift, rotate left and rotate right. Each result is written to the accumulator. A shift by 8 or more yields zero, except the arithmetic right shift, which fills with the sign bit. Rotates use the amount modulo 8.
- R5: Every load and ALU instruction sets Z when the result is zero and N when bit 7 of the result is one. Stores, jumps and branches leave both flags unchanged.
- R6: 0x1B jumps to the operand address and 0x1C to the address read from the operand address. Branch pairs follow, direct form first: 0x1D/0x1E if Z clear, 0x1F/0x20 if Z set, 0x21/0x22 if N clear, 0x23/0x24 if N set. A branch that fails continues at the byte after its operand.
- R7: Indirect store and jump forms perform one extra read at the operand address and use that byte as the effective address.
- R8: The address output carries bits [6:0] of the internal 8-bit address. Write-enable is high for exactly one cycle per store. The data bus is driven by the block only in that cycle and is high-impedance otherwise.
- R9: While the freeze input is high at an opcode-fetch cycle, the machine stays in that cycle with the address of the next opcode on the bus and no register change. Once the input falls, it resumes with that opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| halt_i | input | 1 | Freeze request, honoured at the next opcode fetch |
| addr_o | output | ADDR_PINS (7) | Memory address, low bits of the internal address |
| we_o | output | 1 | Memory write-enable, high in a store's write cycle |
| data_io | inout | 8 | Shared data bus: read by the block, driven only while writing |

## Verification
The freeze request can arrive in the cycle after a store's write, when the machine is about to fetch the next opcode. The bench raises the freeze input right after it observes a write of a counting loop. It then expects the address to stay frozen on the following opcode's address for many cycles with no write. After release, the pending value must arrive exactly once, neither lost nor repeated. A second overlap is a store directly followed by conditional branches. There the flags must survive the store, and the branch direction is judged by which marker write appears.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  localparam int CPU_DW = 8;

  localparam logic [CPU_DW-1:0] OP_LOAD_K    = 8'h01;
  localparam logic [CPU_DW-1:0] OP_LOAD_D    = 8'h02;
  localparam logic [CPU_DW-1:0] OP_STORE_D   = 8'h03;
  localparam logic [CPU_DW-1:0] OP_STORE_I   = 8'h04;
  localparam logic [CPU_DW-1:0] OP_ALU_FIRST = 8'h05;
  localparam logic [CPU_DW-1:0] OP_ALU_LAST  = 8'h1A;
  localparam logic [CPU_DW-1:0] OP_GOTO_D    = 8'h1B;
  localparam logic [CPU_DW-1:0] OP_GOTO_I    = 8'h1C;
  localparam logic [CPU_DW-1:0] OP_BR_FIRST  = 8'h1D;
  localparam logic [CPU_DW-1:0] OP_BR_LAST   = 8'h24;

  typedef enum logic [3:0] {
    ALU_PASSB = 4'd0,
    ALU_ADD   = 4'd1,
    ALU_SUB   = 4'd2,
    ALU_AND   = 4'd3,
    ALU_OR    = 4'd4,
    ALU_XOR   = 4'd5,
    ALU_SHL   = 4'd6,
    ALU_SHR   = 4'd7,
    ALU_SAL   = 4'd8,
    ALU_SAR   = 4'd9,
    ALU_ROL   = 4'd10,
    ALU_ROR   = 4'd11
  } alu_op_e;

  typedef enum logic [1:0] {
    K_NOP   = 2'd0,
    K_ALU   = 2'd1,
    K_STORE = 2'd2,
    K_JUMP  = 2'd3
  } instr_kind_e;

  typedef enum logic [1:0] {
    MD_CONST = 2'd0,
    MD_DIR   = 2'd1,
    MD_IND   = 2'd2
  } opnd_mode_e;

  typedef enum logic [2:0] {
    C_ALWAYS = 3'd0,
    C_ZCLR   = 3'd1,
    C_ZSET   = 3'd2,
    C_NCLR   = 3'd3,
    C_NSET   = 3'd4
  } br_cond_e;

  typedef enum logic [2:0] {
    ST_FETCH   = 3'd0,
    ST_DECODE  = 3'd1,
    ST_OPERAND = 3'd2,
    ST_EXEC    = 3'd3,
    ST_INDIR   = 3'd4,
    ST_WRITE   = 3'd5
  } seq_state_e;

  typedef struct packed {
    instr_kind_e kind;
    opnd_mode_e  mode;
    alu_op_e     op;
    br_cond_e    cond;
  } instr_ctl_t;

endpackage

// File: rtl/acc_cpu_rst_sync.sv
module acc_cpu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = chain_q[STAGES-1];
endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
  import acc_cpu_pkg::*;
#(
  parameter int W = CPU_DW
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  alu_op_e      op_i,
  output logic [W-1:0] y_o,
  output logic         z_o,
  output logic         n_o
);
  localparam int RW = $clog2(W);

  logic [RW-1:0] rot;
  assign rot = b_i[RW-1:0];

  always_comb begin
    unique case (op_i)
      ALU_PASSB: y_o = b_i;
      ALU_ADD:   y_o = a_i + b_i;
      ALU_SUB:   y_o = a_i - b_i;
      ALU_AND:   y_o = a_i & b_i;
      ALU_OR:    y_o = a_i | b_i;
      ALU_XOR:   y_o = a_i ^ b_i;
      ALU_SHL,
      ALU_SAL:   y_o = a_i << b_i;
      ALU_SHR:   y_o = a_i >> b_i;
      ALU_SAR:   y_o = $signed(a_i) >>> b_i;
      ALU_ROL:   y_o = (a_i << rot) | (a_i >> (W - int'(rot)));
      ALU_ROR:   y_o = (a_i >> rot) | (a_i << (W - int'(rot)));
      default:   y_o = a_i;
    endcase
  end

  assign z_o = (y_o == '0);
  assign n_o = y_o[W-1];

  // R4
  always_comb begin
    if ((op_i == ALU_ROL || op_i == ALU_ROR) && rot == '0)
      rot_identity_chk: assert (y_o == a_i);
  end
endmodule

// File: rtl/acc_cpu_decode.sv
module acc_cpu_decode
  import acc_cpu_pkg::*;
(
  input  logic [CPU_DW-1:0] opcode_i,
  output instr_ctl_t        ctl_o
);
  logic [4:0] alu_idx;
  logic [2:0] br_idx;

  assign alu_idx = 5'(opcode_i - OP_ALU_FIRST);
  assign br_idx  = 3'(opcode_i - OP_BR_FIRST);

  always_comb begin
    ctl_o = '{kind: K_NOP, mode: MD_CONST, op: ALU_PASSB, cond: C_ALWAYS};
    if (opcode_i == OP_LOAD_K) begin
      ctl_o.kind = K_ALU;
    end else if (opcode_i == OP_LOAD_D) begin
      ctl_o.kind = K_ALU;
      ctl_o.mode = MD_DIR;
    end else if (opcode_i == OP_STORE_D) begin
      ctl_o.kind = K_STORE;
      ctl_o.mode = MD_DIR;
    end else if (opcode_i == OP_STORE_I) begin
      ctl_o.kind = K_STORE;
      ctl_o.mode = MD_IND;
    end else if (opcode_i >= OP_ALU_FIRST && opcode_i <= OP_ALU_LAST) begin
      ctl_o.kind = K_ALU;
      ctl_o.mode = alu_idx[0] ? MD_DIR : MD_CONST;
      ctl_o.op   = alu_op_e'(alu_idx[4:1] + 4'd1);
    end else if (opcode_i == OP_GOTO_D) begin
      ctl_o.kind = K_JUMP;
      ctl_o.mode = MD_DIR;
    end else if (opcode_i == OP_GOTO_I) begin
      ctl_o.kind = K_JUMP;
      ctl_o.mode = MD_IND;
    end else if (opcode_i >= OP_BR_FIRST && opcode_i <= OP_BR_LAST) begin
      ctl_o.kind = K_JUMP;
      ctl_o.mode = br_idx[0] ? MD_IND : MD_DIR;
      ctl_o.cond = br_cond_e'({1'b0, br_idx[2:1]} + 3'd1);
    end
  end
endmodule

// File: rtl/acc_cpu_seq.sv
module acc_cpu_seq
  import acc_cpu_pkg::*;
(
  input  seq_state_e state_i,
  input  instr_ctl_t ctl_i,
  input  logic       halt_i,
  input  logic       taken_i,
  output seq_state_e state_o,
  output logic       ld_ir_o,
  output logic       pc_inc_o,
  output logic       pc_load_o,
  output logic       ld_m_o,
  output logic       ld_a_o,
  output logic       ld_ccr_o,
  output logic       sel_m_o,
  output logic       we_o
);
  always_comb begin
    state_o   = state_i;
    ld_ir_o   = 1'b0;
    pc_inc_o  = 1'b0;
    pc_load_o = 1'b0;
    ld_m_o    = 1'b0;
    ld_a_o    = 1'b0;
    ld_ccr_o  = 1'b0;
    sel_m_o   = 1'b0;
    we_o      = 1'b0;
    unique case (state_i)
      ST_FETCH: begin
        if (!halt_i) begin
          ld_ir_o  = 1'b1;
          pc_inc_o = 1'b1;
          state_o  = ST_DECODE;
        end
      end
      ST_DECODE: begin
        state_o = (ctl_i.kind == K_NOP) ? ST_FETCH : ST_OPERAND;
      end
      ST_OPERAND: begin
        state_o = ST_FETCH;
        if (ctl_i.kind == K_JUMP && ctl_i.mode == MD_DIR) begin
          pc_load_o = taken_i;
          pc_inc_o  = !taken_i;
        end else if (ctl_i.kind == K_ALU && ctl_i.mode == MD_CONST) begin
          ld_a_o   = 1'b1;
          ld_ccr_o = 1'b1;
          pc_inc_o = 1'b1;
        end else begin
          ld_m_o   = 1'b1;
          pc_inc_o = 1'b1;
          if (ctl_i.mode == MD_IND)       state_o = ST_INDIR;
          else if (ctl_i.kind == K_STORE) state_o = ST_WRITE;
          else                            state_o = ST_EXEC;
        end
      end
      ST_EXEC: begin
        sel_m_o  = 1'b1;
        ld_a_o   = 1'b1;
        ld_ccr_o = 1'b1;
        state_o  = ST_FETCH;
      end
      ST_INDIR: begin
        sel_m_o = 1'b1;
        if (ctl_i.kind == K_STORE) begin
          ld_m_o  = 1'b1;
          state_o = ST_WRITE;
        end else begin
          pc_load_o = taken_i;
          state_o   = ST_FETCH;
        end
      end
      ST_WRITE: begin
        sel_m_o = 1'b1;
        we_o    = 1'b1;
        state_o = ST_FETCH;
      end
      default: state_o = ST_FETCH;
    endcase
  end
endmodule

// File: rtl/acc_cpu_core.sv
module acc_cpu_core
  import acc_cpu_pkg::*;
#(
  parameter int ADDR_PINS = 7
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 halt_i,
  output logic [ADDR_PINS-1:0] addr_o,
  output logic                 we_o,
  inout  wire  [CPU_DW-1:0]    data_io
);
  localparam int CCR_W = 2;
  localparam int Z_BIT = 0;
  localparam int N_BIT = 1;

  logic              rst_n;
  logic [CPU_DW-1:0] a_q, m_q, pc_q, ir_q;
  logic [CCR_W-1:0]  ccr_q;
  seq_state_e        state_q, state_d;
  instr_ctl_t        ctl;
  logic              taken;
  logic              ld_ir, pc_inc, pc_load, ld_m, ld_a, ld_ccr, sel_m, wr;
  logic [CPU_DW-1:0] rd_data, alu_y, addr_full;
  logic              alu_z, alu_n;

  acc_cpu_rst_sync #(.STAGES(2)) u_rst (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rst_no(rst_n)
  );

  acc_cpu_decode u_dec (
    .opcode_i(ir_q),
    .ctl_o   (ctl)
  );

  always_comb begin
    unique case (ctl.cond)
      C_ZCLR:  taken = !ccr_q[Z_BIT];
      C_ZSET:  taken =  ccr_q[Z_BIT];
      C_NCLR:  taken = !ccr_q[N_BIT];
      C_NSET:  taken =  ccr_q[N_BIT];
      default: taken = 1'b1;
    endcase
  end

  acc_cpu_seq u_seq (
    .state_i  (state_q),
    .ctl_i    (ctl),
    .halt_i   (halt_i),
    .taken_i  (taken),
    .state_o  (state_d),
    .ld_ir_o  (ld_ir),
    .pc_inc_o (pc_inc),
    .pc_load_o(pc_load),
    .ld_m_o   (ld_m),
    .ld_a_o   (ld_a),
    .ld_ccr_o (ld_ccr),
    .sel_m_o  (sel_m),
    .we_o     (wr)
  );

  acc_cpu_alu #(.W(CPU_DW)) u_alu (
    .a_i (a_q),
    .b_i (rd_data),
    .op_i(ctl.op),
    .y_o (alu_y),
    .z_o (alu_z),
    .n_o (alu_n)
  );

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_FETCH;
      ir_q    <= '0;
      pc_q    <= '0;
      m_q     <= '0;
      a_q     <= '0;
      ccr_q   <= '0;
    end else begin
      state_q <= state_d;
      if (ld_ir) ir_q <= rd_data;
      if (pc_load)     pc_q <= rd_data;
      else if (pc_inc) pc_q <= pc_q + 1'b1;
      if (ld_m) m_q <= rd_data;
      if (ld_a) a_q <= alu_y;
      if (ld_ccr) begin
        ccr_q[Z_BIT] <= alu_z;
        ccr_q[N_BIT] <= alu_n;
      end
    end
  end

  assign addr_full = sel_m ? m_q : pc_q;
  assign addr_o    = addr_full[ADDR_PINS-1:0];
  assign we_o      = wr;
  assign data_io   = wr ? a_q : 'z;
  assign rd_data   = data_io;

  generate
    if (ADDR_PINS < CPU_DW) begin : g_addr_trim
      logic addr_hi_unused;
      assign addr_hi_unused = |addr_full[CPU_DW-1:ADDR_PINS];
    end
  endgenerate

  // R8
  we_single_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    we_o |=> (!we_o && state_q == ST_FETCH));

  // R9
  halt_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (state_q == ST_FETCH && halt_i) |=>
      (state_q == ST_FETCH && $stable(pc_q) && $stable(ir_q) && $stable(a_q)));

  // R5
  store_keeps_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (state_q == ST_WRITE || state_q == ST_INDIR) |=> $stable(ccr_q));

  // R2
  nop_one_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (state_q == ST_DECODE && ctl.kind == K_NOP) |=>
      (state_q == ST_FETCH && $stable(pc_q) && $stable(a_q)));

  // R6
  branch_fall_through_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (state_q == ST_OPERAND && ctl.kind == K_JUMP && ctl.mode == MD_DIR && !taken) |=>
      (pc_q == $past(pc_q) + 8'd1));
endmodule

// File: tb/acc_cpu_core_test.sv
`timescale 1ns/1ps
module acc_cpu_core_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       halt;
  logic [6:0] addr;
  logic       we;
  wire  [7:0] bus;

  always #2 clk = ~clk;

  acc_cpu_core #(.ADDR_PINS(7)) uut (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .halt_i (halt),
    .addr_o (addr),
    .we_o   (we),
    .data_io(bus)
  );

  logic [7:0] mem [128];
  logic [7:0] img [128];
  logic       load_en;
  logic [6:0] load_a;
  logic [7:0] load_d;

  assign bus = we ? 8'hzz : mem[addr];

  always @(posedge clk) begin
    if (load_en)  mem[load_a] <= load_d;
    else if (we)  mem[addr]   <= bus;
  end

  typedef struct {
    logic [6:0] a;
    logic [7:0] d;
    string      tag;
  } wr_t;

  wr_t expq[$];
  int  vecs = 0;
  int  errs = 0;
  int  bus_err = 0;
  int  cyc = 0;

  // monitor: pops one expected write per observed write cycle
  always @(negedge clk) begin
    wr_t e;
    if (rst_n && we) begin
      vecs++;
      if (expq.size() == 0) begin
        errs++;
        $display("FAIL R6: unexpected write addr=%h data=%h, expected none", addr, bus);
      end else begin
        e = expq.pop_front();
        if (addr !== e.a || bus !== e.d) begin
          errs++;
          $display("FAIL %s: write addr=%h data=%h, expected addr=%h data=%h",
                   e.tag, addr, bus, e.a, e.d);
        end
      end
    end
    if (!we && bus !== mem[addr]) bus_err++;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errs++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  task automatic put2(input int a, input logic [7:0] op, input logic [7:0] opnd);
    img[a]     = op;
    img[a + 1] = opnd;
  endtask

  task automatic expect_wr(input logic [6:0] a, input logic [7:0] d, input string tag);
    wr_t e;
    e.a = a; e.d = d; e.tag = tag;
    expq.push_back(e);
  endtask

  task automatic load_and_reset();
    rst_n = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 128; i++) begin
      load_en = 1'b1;
      load_a  = 7'(i);
      load_d  = img[i];
      @(negedge clk);
    end
    load_en = 1'b0;
    // R1: reset state at the ports
    vecs++;
    if (addr !== 7'h00 || we !== 1'b0) begin
      errs++;
      $display("FAIL R1: addr=%h we=%b, expected addr=00 we=0", addr, we);
    end
    rst_n = 1'b1;
  endtask

  task automatic drain(input int limit);
    wr_t e;
    int  n;
    n = 0;
    while (expq.size() != 0 && n < limit) begin
      @(negedge clk);
      n++;
    end
    repeat (40) @(negedge clk);
    while (expq.size() != 0) begin
      e = expq.pop_front();
      vecs++;
      errs++;
      $display("FAIL %s: write missing, expected addr=%h data=%h", e.tag, e.a, e.d);
    end
  endtask

  initial begin
    logic [6:0] frozen;
    int         moved;
    rst_n   = 1'b0;
    halt    = 1'b0;
    load_en = 1'b0;
    load_a  = '0;
    load_d  = '0;

    // ---------- program 1: loads, ALU, stores, NOP handling ----------
    foreach (img[i]) img[i] = 8'h00;
    put2(0,  8'h01, 8'h05);  put2(2,  8'h05, 8'h03);  put2(4,  8'h03, 8'h40);
    put2(6,  8'h08, 8'h70);  put2(8,  8'h03, 8'h41);
    put2(10, 8'h09, 8'h3C);  put2(12, 8'h0C, 8'h71);  put2(14, 8'h0D, 8'hFF);
    put2(16, 8'h03, 8'h42);
    put2(18, 8'h0F, 8'h03);  put2(20, 8'h03, 8'h43);
    put2(22, 8'h01, 8'h90);  put2(24, 8'h15, 8'h02);  put2(26, 8'h03, 8'h44);
    put2(28, 8'h11, 8'h04);  put2(30, 8'h18, 8'h72);  put2(32, 8'h03, 8'h45);
    put2(34, 8'h19, 8'h01);  put2(36, 8'h13, 8'h09);  put2(38, 8'h03, 8'h46);
    put2(40, 8'h01, 8'hA5);  put2(42, 8'h19, 8'h04);  put2(44, 8'h03, 8'h47);
    put2(46, 8'h02, 8'h73);  put2(48, 8'h12, 8'h74);  put2(50, 8'h03, 8'h48);
    put2(52, 8'h03, 8'hC9);
    img[54] = 8'h80;
    img[55] = 8'h00;
    put2(56, 8'h01, 8'h11);  put2(58, 8'h04, 8'h75);  put2(60, 8'h1B, 8'h3C);
    img[8'h70] = 8'h0A; img[8'h71] = 8'h81; img[8'h72] = 8'h0B;
    img[8'h73] = 8'hC3; img[8'h74] = 8'h02; img[8'h75] = 8'h50;

    expect_wr(7'h40, 8'h08, "R3");
    expect_wr(7'h41, 8'hFE, "R4");
    expect_wr(7'h42, 8'h42, "R4");
    expect_wr(7'h43, 8'h10, "R4");
    expect_wr(7'h44, 8'hE4, "R4");
    expect_wr(7'h45, 8'h70, "R4");
    expect_wr(7'h46, 8'h00, "R4");
    expect_wr(7'h47, 8'h5A, "R4");
    expect_wr(7'h48, 8'h30, "R3");
    expect_wr(7'h49, 8'h30, "R8");
    expect_wr(7'h50, 8'h11, "R2");
    load_and_reset();
    drain(2000);

    // ---------- program 2: flags, branches, indirect jumps ----------
    foreach (img[i]) img[i] = 8'h00;
    put2(0,  8'h01, 8'h00);  put2(2,  8'h1D, 8'h60);  put2(4,  8'h1F, 8'h08);
    put2(6,  8'h03, 8'h5F);  put2(8,  8'h07, 8'h01);  put2(10, 8'h21, 8'h60);
    put2(12, 8'h24, 8'h70);  put2(14, 8'h03, 8'h5F);  put2(16, 8'h03, 8'h50);
    put2(18, 8'h23, 8'h16);  put2(20, 8'h03, 8'h5F);  put2(22, 8'h01, 8'h7F);
    put2(24, 8'h20, 8'h71);  put2(26, 8'h22, 8'h71);  put2(28, 8'h03, 8'h5F);
    put2(32, 8'h03, 8'h52);  put2(34, 8'h1E, 8'h72);  put2(36, 8'h03, 8'h5F);
    put2(40, 8'h1C, 8'h73);  put2(42, 8'h03, 8'h5F);  put2(44, 8'h03, 8'h53);
    put2(46, 8'h1B, 8'h2E);
    put2(8'h60, 8'h03, 8'h5E); put2(8'h62, 8'h1B, 8'h62);
    img[8'h70] = 8'h10; img[8'h71] = 8'h20; img[8'h72] = 8'h28; img[8'h73] = 8'h2C;

    expect_wr(7'h50, 8'hFF, "R5");
    expect_wr(7'h52, 8'h7F, "R6");
    expect_wr(7'h53, 8'h7F, "R7");
    load_and_reset();
    drain(2000);

    // ---------- program 3: counting loop with a freeze request ----------
    foreach (img[i]) img[i] = 8'h00;
    put2(0, 8'h01, 8'h01);  put2(2, 8'h05, 8'h01);
    put2(4, 8'h03, 8'h40);  put2(6, 8'h1B, 8'h02);
    expect_wr(7'h40, 8'h02, "R9");
    expect_wr(7'h40, 8'h03, "R9");
    expect_wr(7'h40, 8'h04, "R9");
    load_and_reset();
    for (int n = 0; n < 2000 && expq.size() != 1; n++) @(posedge clk);
    @(negedge clk);
    halt = 1'b1;
    repeat (3) @(negedge clk);
    frozen = addr;
    moved  = 0;
    for (int n = 0; n < 30; n++) begin
      @(negedge clk);
      if (addr !== frozen || we !== 1'b0) moved++;
    end
    // R9: frozen at the fetch of the opcode after the store
    vecs++;
    if (moved != 0 || frozen !== 7'h06) begin
      errs++;
      $display("FAIL R9: frozen addr=%h changes=%0d, expected addr=06 changes=0", frozen, moved);
    end
    vecs++;
    if (expq.size() != 1) begin
      errs++;
      $display("FAIL R9: pending writes=%0d, expected 1", expq.size());
    end
    halt = 1'b0;
    for (int n = 0; n < 2000 && expq.size() != 0; n++) @(posedge clk);
    @(negedge clk);
    halt = 1'b1;
    drain(10);

    // R8: bus never driven by the block outside write cycles
    vecs++;
    if (bus_err != 0) begin
      errs++;
      $display("FAIL R8: bus mismatches outside writes=%0d, expected 0", bus_err);
    end

    rst_n = 1'b0;
    halt  = 1'b0;
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule